// File: doc/BRIEF.md
# Circular-Buffer FIFO with Fill-Direction Tracking

This block is a single-clock first-in/first-out queue placed between a producing unit and a consuming unit. Words are kept in a two-port synchronous RAM. One port takes writes and the other gives reads. Two free-running address counters walk the RAM as a ring. A write advances the write counter and a read advances the read counter.

When the two counters hold the same value, the queue is either completely full or completely empty. A one-bit direction register settles which of the two it is. The register records whether the last unbalanced operation was a write (the queue is filling) or a read (the queue is draining). Both flags come from this single address compare, so the counters need no extra wrap bit.

The caller must not write while `full_o` is high unless it also reads in that cycle. It must never read while `empty_o` is high.

Top module: `dp_fifo_dir`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no traffic, the outputs are `empty_o`=1, `full_o`=0 and `rd_data_o`=0.
- R2: Words leave in the order they entered. The word for a read appears on `rd_data_o` after the rising clock edge that samples `rd_en_i`=1.
- R3: `full_o` rises after the edge that stores word number 2**ADDR_W (256 with the defaults) with no read taken. It stays low while the occupancy is smaller.
- R4: `empty_o` rises after the edge that takes the last stored word, and it stays low while at least one word is held.
- R5: A cycle with `wr_en_i`=1 and `rd_en_i`=1 leaves `full_o` and `empty_o` unchanged. On a full queue, that read returns the oldest word, not the word being written.
- R6: Both address counters wrap from 2**ADDR_W-1 to 0, and ordering and flags stay correct across the wrap.
- R7: `rd_data_o` holds its value in every cycle that samples `rd_en_i`=0.
- R8: `full_o` and `empty_o` are never high together.
- R9: After a write-only cycle `empty_o` is 0, and after a read-only cycle `full_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Store `wr_data_i` this cycle |
| wr_data_i | input | DATA_W | Word to store |
| rd_en_i | input | 1 | Take the oldest word this cycle |
| rd_data_o | output | DATA_W | Last word taken, registered |
| full_o | output | 1 | Every location holds an unread word |
| empty_o | output | 1 | No unread word is held |

## Verification
The embedded properties assume the caller never overruns or underruns the queue. That means no write-only cycle while full and no read of any kind while empty. Under a violation, the direction register and the counters no longer describe the occupancy. The bench keeps a queue model and decides each cycle's requests from the model's occupancy, so it never issues such a cycle. It still drives writes and reads on the same cycle at the full boundary, and it drives long mixed runs that carry both counters through their wrap.

// File: rtl/dpfifo_pkg.sv
package dpfifo_pkg;
  typedef enum logic {
    DIR_DRAIN = 1'b0,
    DIR_FILL  = 1'b1
  } dir_e;
endpackage

// File: rtl/fifo_ptr.sv
module fifo_ptr #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  // natural binary wrap from all-ones to zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (inc_i) ptr_o <= ptr_o + ONE;
  end
endmodule

// File: rtl/fifo_dpram.sv
module fifo_dpram #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read-before-write on a shared address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o)); // R7
endmodule

// File: rtl/fifo_dir_ctrl.sv
module fifo_dir_ctrl
  import dpfifo_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] wptr_i,
  input  logic [AW-1:0] rptr_i,
  output logic          full_o,
  output logic          empty_o
);
  dir_e dir_q, dir_d;
  logic ptr_eq;

  always_comb begin
    dir_d = dir_q;
    if (wr_i && !rd_i)      dir_d = DIR_FILL;
    else if (rd_i && !wr_i) dir_d = DIR_DRAIN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= DIR_DRAIN;
    else         dir_q <= dir_d;
  end

  assign ptr_eq  = (wptr_i == rptr_i);
  assign full_o  = ptr_eq && (dir_q == DIR_FILL);
  assign empty_o = ptr_eq && (dir_q == DIR_DRAIN);

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o)); // R8
  AST_WR_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i) |=> !empty_o); // R9
  AST_RD_NOT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> !full_o); // R9
  AST_BOTH_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i) |=> ($stable(full_o) && $stable(empty_o))); // R5
  AST_FULL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_o && !(wr_i && !rd_i)) |=> !full_o); // R3
  AST_EMPTY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && !(rd_i && !wr_i)) |=> !empty_o); // R4
endmodule

// File: rtl/dp_fifo_dir.sv
module dp_fifo_dir #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [ADDR_W-1:0] wptr, rptr;

  fifo_ptr #(.AW(ADDR_W)) u_wptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(wr_en_i), .ptr_o(wptr)
  );

  fifo_ptr #(.AW(ADDR_W)) u_rptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(rd_en_i), .ptr_o(rptr)
  );

  fifo_dpram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(wr_en_i), .waddr_i(wptr), .wdata_i(wr_data_i),
    .re_i(rd_en_i), .raddr_i(rptr), .rdata_o(rd_data_o)
  );

  fifo_dir_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr_en_i), .rd_i(rd_en_i),
    .wptr_i(wptr), .rptr_i(rptr),
    .full_o(full_o), .empty_o(empty_o)
  );

  AST_RST_EMPTY: assert property (@(posedge clk_i)
    !rst_ni |-> (empty_o && !full_o)); // R1
  AST_WRAP_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (&wptr)) |=> (wptr == '0)); // R6
endmodule

// File: tb/dp_fifo_dir_tb.sv
`timescale 1ns/1ps
module dp_fifo_dir_tb;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic full, empty;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] model_q [$];
  logic [DW-1:0] last_rd = '0;
  bit done = 0;

  always #4 clk = ~clk;

  dp_fifo_dir #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .full_o(full), .empty_o(empty)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one cycle, then check outputs at the following falling edge
  task automatic step(input bit w, input bit r, input logic [DW-1:0] d, input string req);
    wr_en = w; rd_en = r; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (r) last_rd = model_q.pop_front();
    if (w) model_q.push_back(d);
    check({req, " data"}, int'(rd_data), int'(last_rd));
    check("R3 full",  int'(full),  int'(model_q.size() == DEPTH));
    check("R4 empty", int'(empty), int'(model_q.size() == 0));
    check("R8 excl",  int'(full && empty), 0);
  endtask

  task automatic t_reset();
    check("R1 empty", int'(empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 data", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 empty after release", int'(empty), 1);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) step(1, 0, DW'(8'hA0 + i), "R9");
    check("R9 not empty", int'(empty), 0);
    for (int i = 0; i < 5; i++) step(0, 1, '0, "R2");
    step(0, 0, '0, "R7");
    step(0, 0, '0, "R7");
    check("R7 hold", int'(rd_data), 8'hA4);
  endtask

  task automatic t_fill_full();
    for (int i = 0; i < DEPTH - 1; i++) step(1, 0, DW'(i * 7 + 3), "R3");
    check("R3 not full at depth-1", int'(full), 0);
    step(1, 0, 8'h5C, "R3");
    check("R3 full at depth", int'(full), 1);
    for (int i = 0; i < 4; i++) step(1, 1, DW'(8'hE0 + i), "R5");
    check("R5 still full", int'(full), 1);
    step(0, 1, '0, "R9");
    check("R9 not full after read", int'(full), 0);
  endtask

  task automatic t_drain();
    while (model_q.size() > 1) step(0, 1, '0, "R2");
    check("R4 not empty with one", int'(empty), 0);
    step(0, 1, '0, "R4");
    check("R4 empty", int'(empty), 1);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 700; i++) begin
      bit w, r;
      w = (i % 5) != 4;
      r = (i % 3) == 0;
      if (model_q.size() == DEPTH && !r) w = 0;
      if (model_q.size() == 0) r = 0;
      step(w, r, DW'(i ^ (i >> 3)), "R6");
    end
    while (model_q.size() > 0) step(0, 1, '0, "R6");
    check("R6 empty after wrap", int'(empty), 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_order();
    t_fill_full();
    t_drain();
    t_wrap();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule